// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a memory-mapped real-time clock that counts whole seconds in a 32-bit unsigned register. A slow enable input, pulsing at 32.768 kHz, feeds a prescaler that produces one tick per second. The counter advances on those ticks only while a run bit in the control register is set. Software can overwrite the running count through a load register and can read the live count at any time.

A 32-bit match register holds an alarm time. When the count first becomes equal to the match value, a sticky raw alarm flag is raised. Software sees the flag in a raw status register and in a masked status register, which is the raw flag gated by an enable bit. It clears the flag by writing a one to a clear register. The single interrupt output follows the masked status. The register bus is a plain address, write strobe, write data and read data port. Reads are combinational and writes take effect at the clock edge.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the count, match, control, alarm-enable and raw-alarm registers are all zero, every register reads zero, and `irq_o` is low.
- R2: With control bit 0 set, the count rises by one at the clock edge that samples the TICKS_PER_SEC-th `khz_en` pulse since the last tick or load. With control bit 0 clear, `khz_en` pulses change neither the count nor the prescaler phase.
- R3: A write to byte offset 0x08 replaces the count from the next cycle on and restarts the prescaler phase. A read of offset 0x00 returns the live count. Writes to offset 0x00 are ignored.
- R4: The count is an unsigned 32-bit value: a tick at 0xFFFFFFFF gives 0.
- R5: The match register at offset 0x04 is written and read back in all 32 bits.
- R6: Bit 0 of the raw status at offset 0x14 goes to 1 one clock after the first cycle in which the count equals the match value, whatever the alarm-enable bit holds. It stays at 1 while the two stay equal and afterwards, until it is cleared. The equality of the reset values does not set it.
- R7: Writing a value with bit 0 set to offset 0x1C clears the raw alarm flag. A write with bit 0 clear leaves it unchanged, and offset 0x1C reads zero.
- R8: When the alarm sets in the same cycle as a clear write, the flag ends up set.
- R9: Bit 0 at offset 0x10 is the alarm enable and reads back. Bit 0 of the masked status at offset 0x18 equals raw AND enable, and `irq_o` equals that masked bit.
- R10: The control register at offset 0x0C keeps only bit 0 (run), and its other bits read zero. Offsets 0x20 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| khz_en | input | 1 | One-cycle enable pulse at the 32.768 kHz rate |
| bus_addr | input | ADDR_W (6) | Byte address; bits [1:0] are ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4, so a full prescaler period takes only four enable pulses. That makes it cheap to sweep the count over every pulse index across two and a half seconds from several start values, including one just below the 32-bit wrap. With such short seconds, the bench can also walk the count into the match value, across the wrap into a match of zero, and into a same-cycle set and clear, all within a few hundred clocks.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int unsigned REG_W = 32;

  // Word indices (byte offset / 4) of the register window
  localparam int unsigned WI_COUNT  = 0;
  localparam int unsigned WI_MATCH  = 1;
  localparam int unsigned WI_LOAD   = 2;
  localparam int unsigned WI_CTRL   = 3;
  localparam int unsigned WI_AL_EN  = 4;
  localparam int unsigned WI_RAW    = 5;
  localparam int unsigned WI_MASKED = 6;
  localparam int unsigned WI_CLR    = 7;

  typedef struct packed {
    logic load;
    logic match;
    logic ctrl;
    logic al_en;
    logic clr;
  } wr_strobe_t;
endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic khz_en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          tick;

  always_comb begin
    phase_d = phase_q;
    tick    = 1'b0;
    if (restart_i) begin
      phase_d = '0;
    end else if (run_i && khz_en_i) begin
      if (phase_q == LAST) begin
        phase_d = '0;
        tick    = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick_o = tick;

  p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (run_i && khz_en_i && !restart_i));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         match_wr_i,
  input  logic [W-1:0] match_val_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] match_o,
  output logic         hit_o
);
  logic [W-1:0] count_q, count_d, match_q, match_d;
  logic         eq, eq_q;

  always_comb begin
    count_d = count_q;
    if (load_i)      count_d = load_val_i;
    else if (tick_i) count_d = count_q + 1'b1;
    match_d = match_wr_i ? match_val_i : match_q;
  end

  assign eq = (count_q == match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
      eq_q    <= 1'b1;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
      eq_q    <= eq;
    end
  end

  assign hit_o   = eq && !eq_q;
  assign count_o = count_q;
  assign match_o = match_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(count_o));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_val_i)));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && (&count_o)) |=> (count_o == '0));
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  output logic raw_o,
  output logic en_o,
  output logic irq_o
);
  logic raw_q, raw_d, en_q, en_d;

  always_comb begin
    raw_d = raw_q;
    if (hit_i)      raw_d = 1'b1;
    else if (clr_i) raw_d = 1'b0;
    en_d = en_wr_i ? en_val_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = raw_q & en_q;

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o && !clr_i) |=> raw_o);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !raw_o);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && clr_i) |=> raw_o);
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           khz_en,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_we,
  input  logic [rtc_sec_pkg::REG_W-1:0]  bus_wdata,
  output logic [rtc_sec_pkg::REG_W-1:0]  bus_rdata,
  output logic                           irq_o
);
  import rtc_sec_pkg::*;
  localparam int unsigned WIX_W = ADDR_W - 2;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [WIX_W-1:0] widx;
  wr_strobe_t       wr;
  assign widx = bus_addr[ADDR_W-1:2];

  always_comb begin
    wr       = '0;
    wr.load  = bus_we && (widx == WIX_W'(WI_LOAD));
    wr.match = bus_we && (widx == WIX_W'(WI_MATCH));
    wr.ctrl  = bus_we && (widx == WIX_W'(WI_CTRL));
    wr.al_en = bus_we && (widx == WIX_W'(WI_AL_EN));
    wr.clr   = bus_we && (widx == WIX_W'(WI_CLR)) && bus_wdata[0];
  end

  logic run_q, run_d;
  always_comb run_d = wr.ctrl ? bus_wdata[0] : run_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  logic             tick, hit, raw, al_en, irq;
  logic [REG_W-1:0] count, match;

  rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_ni), .run_i(run_q), .khz_en_i(khz_en),
    .restart_i(wr.load), .tick_o(tick)
  );

  rtc_sec_counter #(.W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick_i(tick), .load_i(wr.load),
    .load_val_i(bus_wdata), .match_wr_i(wr.match), .match_val_i(bus_wdata),
    .count_o(count), .match_o(match), .hit_o(hit)
  );

  rtc_sec_alarm u_alarm (
    .clk(clk), .rst_n(rst_ni), .hit_i(hit), .clr_i(wr.clr),
    .en_wr_i(wr.al_en), .en_val_i(bus_wdata[0]),
    .raw_o(raw), .en_o(al_en), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (widx == WIX_W'(WI_COUNT))       bus_rdata = count;
    else if (widx == WIX_W'(WI_MATCH))  bus_rdata = match;
    else if (widx == WIX_W'(WI_CTRL))   bus_rdata[0] = run_q;
    else if (widx == WIX_W'(WI_AL_EN))  bus_rdata[0] = al_en;
    else if (widx == WIX_W'(WI_RAW))    bus_rdata[0] = raw;
    else if (widx == WIX_W'(WI_MASKED)) bus_rdata[0] = irq;
  end

  assign irq_o = irq;

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (raw && al_en));
endmodule

// File: tb/rtc_seconds_alarm_tb_top.sv
module rtc_seconds_alarm_tb_top;
  localparam int unsigned T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        khz_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_seconds_alarm #(.TICKS_PER_SEC(T), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .khz_en(khz_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); khz_en = 1'b1;
      @(negedge clk); khz_en = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] starts [4];
    starts[0] = 32'h0; starts[1] = 32'h5;
    starts[2] = 32'h7FFF_FFFF; starts[3] = 32'hFFFF_FFFE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of every register and the interrupt
    for (int a = 0; a < 8; a++) begin
      rd(6'(a * 4), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

    // R5: match readback
    wr(6'h04, 32'hA5A5_5A5A);
    rd(6'h04, v); chk("R5 match readback", v, 32'hA5A5_5A5A);

    // R10: control keeps only bit 0; unmapped reads zero
    wr(6'h0C, 32'hFFFF_FFFE);
    rd(6'h0C, v); chk("R10 ctrl upper bits", v, 32'h0);
    rd(6'h20, v); chk("R10 unmapped 0x20", v, 32'h0);
    rd(6'h3C, v); chk("R10 unmapped 0x3C", v, 32'h0);

    // R3: write to count offset ignored
    wr(6'h00, 32'h1234);
    rd(6'h00, v); chk("R3 count write ignored", v, 32'h0);

    // R2, R4: sweep pulse index from several start values
    wr(6'h04, 32'hDEAD_0000);
    foreach (starts[s]) begin
      wr(6'h08, starts[s]);
      wr(6'h0C, 32'h1);
      rd(6'h0C, v); chk("R10 ctrl bit0 readback", v, 32'h1);
      for (int k = 0; k < 10; k++) begin
        rd(6'h00, v);
        chk((starts[s] == 32'hFFFF_FFFE && k >= 8) ? "R4 wrap" : "R2 tick count",
            v, starts[s] + 32'(k / T));
        pulse(1);
      end
      wr(6'h0C, 32'h0);
    end

    // R2: disabled counter ignores pulses
    wr(6'h08, 32'd100);
    pulse(8);
    rd(6'h00, v); chk("R2 disabled hold", v, 32'd100);

    // R3: load restarts prescaler phase
    wr(6'h0C, 32'h1);
    wr(6'h08, 32'd200);
    pulse(3);
    wr(6'h08, 32'd300);
    rd(6'h00, v); chk("R3 load value", v, 32'd300);
    pulse(3);
    rd(6'h00, v); chk("R3 phase restarted", v, 32'd300);
    pulse(1);
    rd(6'h00, v); chk("R3 first tick after load", v, 32'd301);
    wr(6'h0C, 32'h0);

    // R6: reset-time equality did not set raw
    rd(6'h14, v); chk("R6 no alarm yet", v, 32'h0);

    // R6, R9, R7: alarm by counting into match with enable off
    wr(6'h10, 32'h0);
    wr(6'h04, 32'd500);
    wr(6'h08, 32'd497);
    wr(6'h0C, 32'h1);
    pulse(3 * T - 1);
    rd(6'h14, v); chk("R6 raw before match", v, 32'h0);
    pulse(1);
    rd(6'h00, v); chk("R6 count at match", v, 32'd500);
    rd(6'h14, v); chk("R6 raw set unmasked", v, 32'h1);
    rd(6'h18, v); chk("R9 masked while disabled", v, 32'h0);
    chk("R9 irq while disabled", {31'h0, irq_o}, 32'h0);
    pulse(T);
    rd(6'h14, v); chk("R6 raw sticky", v, 32'h1);
    wr(6'h0C, 32'h0);
    wr(6'h10, 32'h1);
    rd(6'h10, v); chk("R9 enable readback", v, 32'h1);
    rd(6'h18, v); chk("R9 masked set", v, 32'h1);
    chk("R9 irq asserted", {31'h0, irq_o}, 32'h1);
    wr(6'h1C, 32'hFFFF_FFFE);
    rd(6'h14, v); chk("R7 clear bit0 zero no effect", v, 32'h1);
    wr(6'h1C, 32'h1);
    rd(6'h14, v); chk("R7 raw cleared", v, 32'h0);
    chk("R7 irq dropped", {31'h0, irq_o}, 32'h0);
    rd(6'h1C, v); chk("R7 clear reads zero", v, 32'h0);

    // R8: load into match and clear in the same cycle as the set
    wr(6'h04, 32'h777);
    @(negedge clk);
    bus_addr = 6'h08; bus_wdata = 32'h777; bus_we = 1'b1;
    @(negedge clk);
    bus_addr = 6'h1C; bus_wdata = 32'h1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(6'h14, v); chk("R8 set wins over clear", v, 32'h1);
    wr(6'h1C, 32'h1);
    repeat (3) @(negedge clk);
    rd(6'h14, v); chk("R6 no retrigger while equal", v, 32'h0);

    // R4, R6: wrap into match of zero
    wr(6'h04, 32'h0);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'h1);
    pulse(T);
    rd(6'h00, v); chk("R4 wrap to zero", v, 32'h0);
    rd(6'h14, v); chk("R6 alarm at wrap", v, 32'h1);
    chk("R9 irq at wrap", {31'h0, irq_o}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule